// File: doc/BRIEF.md
# AES-128 Round Sequencing Controller

This block is the finite-state controller that steps an AES-128 encryption datapath through its pre-round key addition, its ten rounds and a final output capture. The datapath reads its byte substitution table from a synchronous memory, so each substitution result arrives one clock after its address. The controller therefore holds every round for two clocks. A small dwell counter makes the state advance only on the second clock of a round. The controller drives one enable for each datapath operation: byte substitution, row shift, column mixing and round-key addition. It also drives a round number for the key schedule, a one-cycle capture strobe for the output register, and a done flag.

A transfer agent holds `load` high while it shifts plaintext and key into the datapath. It then drops `load` to start the encryption. The controller waits in an idle state and reacts only to a high-to-low change of `load` seen on two successive clock edges. It runs the sequence to completion without further input, then rests in a done state with `done` high. A new high-then-low pulse on `load` starts the next block.

Top module: `aes_round_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all four operation enables, `capture` and `done` are 0 and `round_num` is 0.
- R2: In an idle state, the sequence starts only at a clock edge where `load` is sampled 0 and was sampled 1 at the previous edge. A `load` held at 1, or held at 0, keeps the controller idle with all enables 0.
- R3: The first active cycle after a start is the pre-round. For exactly one cycle, only `key_add_en` is 1, and `round_num` is 0.
- R4: Rounds 1 to 10 each last exactly two clock cycles in order. `round_num` equals the round number (1 to 10) on both cycles.
- R5: During rounds 1 to 9, all four operation enables are 1.
- R6: During round 10, `mix_en` is 0 while `sub_en`, `shift_en` and `key_add_en` are 1.
- R7: The cycle after round 10 has `capture` at 1 for exactly one cycle, with all operation enables at 0 and `round_num` at 0. It is followed directly by the done state.
- R8: `done` first becomes 1 on the 22nd clock edge after the start edge. It stays 1, with all enables and `capture` at 0, until the next start.
- R9: From the done state, a high-then-low pulse on `load` restarts the sequence at the pre-round. `done` drops on that same edge.
- R10: Changes of `load` while the sequence is active have no effect on its order or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset to the power-up idle state |
| load | input | 1 | High while data is being loaded; its falling change starts a block |
| sub_en | output | 1 | Enable for the byte substitution step |
| shift_en | output | 1 | Enable for the row shift step |
| mix_en | output | 1 | Enable for the column mixing step |
| key_add_en | output | 1 | Enable for the round-key addition step |
| round_num | output | 4 | Current round number for key expansion, 0 outside rounds |
| capture | output | 1 | One-cycle strobe to load the final ciphertext register |
| done | output | 1 | High while resting after a completed block |

## Verification
The embedded assertions check on every cycle that column mixing never runs without the other three operations. They also check that a round state holds still across its first clock, that a capture is always followed by done, that done carries no enable, and that an idle start goes to the pre-round. Only the bench's scenarios can show the full cycle-by-cycle enable pattern and the exact 22-edge latency to done. The same holds for restarting from the done state, for indifference to `load` activity mid-sequence, and for a reset that lands in the middle of a round.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

    localparam int AES128_ROUNDS = 10;

    typedef struct packed {
        logic sub;
        logic shift;
        logic mix;
        logic key_add;
    } op_en_t;

    localparam op_en_t OPS_NONE     = '{sub: 1'b0, shift: 1'b0, mix: 1'b0, key_add: 1'b0};
    localparam op_en_t OPS_KEY_ONLY = '{sub: 1'b0, shift: 1'b0, mix: 1'b0, key_add: 1'b1};
    localparam op_en_t OPS_FULL     = '{sub: 1'b1, shift: 1'b1, mix: 1'b1, key_add: 1'b1};
    localparam op_en_t OPS_FINAL    = '{sub: 1'b1, shift: 1'b1, mix: 1'b0, key_add: 1'b1};

endpackage

// File: rtl/aes_seq_start_detect.sv
module aes_seq_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic load_fell
);
    logic load_d, load_q;

    always_comb begin
        load_d = load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= load_d;
    end

    // high at the previous edge, low now
    assign load_fell = load_q & ~load;
endmodule

// File: rtl/aes_seq_dwell.sv
module aes_seq_dwell #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic last
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = active && (cnt_q == CNT_LAST);
        cnt_d = cnt_q;
        if (!active || last) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/aes_seq_decode.sv
module aes_seq_decode
    import aes_seq_pkg::*;
#(
    parameter int NUM_ROUNDS = AES128_ROUNDS,
    parameter int SW = $clog2(NUM_ROUNDS + 4),
    parameter int RW = $clog2(NUM_ROUNDS + 1)
) (
    input  logic [SW-1:0] state,
    output op_en_t        ops,
    output logic [RW-1:0] round_num,
    output logic          in_round,
    output logic          capture,
    output logic          done
);
    localparam logic [SW-1:0] S_PRE  = SW'(1);
    localparam logic [SW-1:0] S_R1   = SW'(2);
    localparam logic [SW-1:0] S_RLST = SW'(NUM_ROUNDS + 1);
    localparam logic [SW-1:0] S_BUF  = SW'(NUM_ROUNDS + 2);
    localparam logic [SW-1:0] S_DONE = SW'(NUM_ROUNDS + 3);

    always_comb begin
        ops       = OPS_NONE;
        round_num = '0;
        in_round  = (state >= S_R1) && (state <= S_RLST);
        capture   = (state == S_BUF);
        done      = (state == S_DONE);
        if (state == S_PRE) begin
            ops = OPS_KEY_ONLY;
        end else if (in_round) begin
            round_num = RW'(state - S_PRE);
            ops       = (state == S_RLST) ? OPS_FINAL : OPS_FULL;
        end
    end
endmodule

// File: rtl/aes_round_sequencer.sv
module aes_round_sequencer
    import aes_seq_pkg::*;
#(
    parameter int NUM_ROUNDS   = AES128_ROUNDS,
    parameter int ROUND_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    output logic       sub_en,
    output logic       shift_en,
    output logic       mix_en,
    output logic       key_add_en,
    output logic [3:0] round_num,
    output logic       capture,
    output logic       done
);
    localparam int SW = $clog2(NUM_ROUNDS + 4);
    localparam int RW = $clog2(NUM_ROUNDS + 1);
    localparam logic [SW-1:0] S_IDLE = '0;
    localparam logic [SW-1:0] S_PRE  = SW'(1);
    localparam logic [SW-1:0] S_BUF  = SW'(NUM_ROUNDS + 2);
    localparam logic [SW-1:0] S_DONE = SW'(NUM_ROUNDS + 3);

    typedef struct packed {
        logic [SW-1:0] state;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic          load_fell, in_round, round_last, cap_w, done_w;
    op_en_t        ops;
    logic [RW-1:0] rnd;

    aes_seq_start_detect u_start (
        .clk(clk), .rst_n(rst_n), .load(load), .load_fell(load_fell)
    );

    aes_seq_dwell #(.CYCLES(ROUND_CYCLES)) u_dwell (
        .clk(clk), .rst_n(rst_n), .active(in_round), .last(round_last)
    );

    aes_seq_decode #(.NUM_ROUNDS(NUM_ROUNDS), .SW(SW), .RW(RW)) u_dec (
        .state(seq_q.state), .ops(ops), .round_num(rnd),
        .in_round(in_round), .capture(cap_w), .done(done_w)
    );

    always_comb begin
        seq_d = seq_q;
        if (seq_q.state == S_IDLE || seq_q.state == S_DONE) begin
            if (load_fell) seq_d.state = S_PRE;
        end else if (in_round) begin
            if (round_last) seq_d.state = seq_q.state + SW'(1);
        end else if (seq_q.state == S_BUF) begin
            seq_d.state = S_DONE;
        end else begin
            seq_d.state = seq_q.state + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: S_IDLE};
        else        seq_q <= seq_d;
    end

    assign sub_en     = ops.sub;
    assign shift_en   = ops.shift;
    assign mix_en     = ops.mix;
    assign key_add_en = ops.key_add;
    assign round_num  = 4'(rnd);
    assign capture    = cap_w;
    assign done       = done_w;

    assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == S_IDLE || seq_q.state == S_DONE) && load_fell) |=> (seq_q.state == S_PRE));

    assert_round_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_round && !round_last) |=> ($stable(seq_q.state) && $stable(round_num)));

    assert_mix_with_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mix_en |-> (sub_en && shift_en && key_add_en));

    assert_capture_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sub_en && !shift_en && !mix_en && !key_add_en && !capture));

    assert_active_ignores_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_round && !round_last) |=> !capture && !done);
endmodule

// File: tb/tb_aes_round_sequencer.sv
module tb_aes_round_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic sub_en, shift_en, mix_en, key_add_en, capture, done;
    logic [3:0] round_num;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [9:0] v;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    aes_round_sequencer dut (
        .clk(clk), .rst_n(rst_n), .load(load),
        .sub_en(sub_en), .shift_en(shift_en), .mix_en(mix_en), .key_add_en(key_add_en),
        .round_num(round_num), .capture(capture), .done(done)
    );

    // packing: {sub, shift, mix, key_add, round[3:0], capture, done}
    function automatic logic [9:0] pk(input logic [3:0] ops, input int rnd,
                                      input logic cap, input logic dn);
        return {ops, 4'(rnd), cap, dn};
    endfunction

    // monitor: compares one expected item per clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [9:0] act;
            e = q.pop_front();
            act = {sub_en, shift_en, mix_en, key_add_en, round_num, capture, done};
            checks++;
            if (act !== e.v) begin
                errors++;
                $display("FAIL %s: actual %b expected %b", e.tag, act, e.v);
            end
        end
    end

    task automatic step(input logic ld, input logic [9:0] v, input string tag);
        @(negedge clk);
        load = ld;
        q.push_back('{v: v, tag: tag});
    endtask

    task automatic idle_steps(input int n, input logic ld, input logic dn, input string tag);
        for (int i = 0; i < n; i++) step(ld, pk(4'b0000, 0, 1'b0, dn), tag);
    endtask

    // one block: arming pulse then full sequence; toggle wiggles load mid-run
    task automatic run_block(input logic was_done, input bit toggle, input string tag);
        step(1'b1, pk(4'b0000, 0, 1'b0, was_done), {tag, " R2 arm"});
        step(1'b0, pk(4'b0001, 0, 1'b0, 1'b0), {tag, " R3 pre-round"});
        for (int r = 1; r <= 10; r++) begin
            for (int c = 0; c < 2; c++) begin
                logic ld;
                ld = (toggle && r < 10) ? logic'((r + c) % 2) : 1'b0;
                if (r < 10) step(ld, pk(4'b1111, r, 1'b0, 1'b0), {tag, " R4 R5 R10 round"});
                else        step(ld, pk(4'b1101, r, 1'b0, 1'b0), {tag, " R4 R6 final round"});
            end
        end
        step(1'b0, pk(4'b0000, 0, 1'b1, 1'b0), {tag, " R7 capture"});
        // 22nd edge after the start edge
        step(1'b0, pk(4'b0000, 0, 1'b0, 1'b1), {tag, " R8 done latency"});
    endtask

    initial begin
        // R1: reset state
        idle_steps(3, 1'b0, 1'b0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        q.push_back('{v: pk(4'b0000, 0, 1'b0, 1'b0), tag: "R1 after reset"});
        // R2: load held low, then held high, stays idle
        idle_steps(4, 1'b0, 1'b0, "R2 load low idle");
        idle_steps(5, 1'b1, 1'b0, "R2 load high idle");
        step(1'b1, pk(4'b0000, 0, 1'b0, 1'b0), "R2 still idle");
        run_block(1'b0, 1'b0, "blk1");
        // R8: done holds with load low and high
        idle_steps(4, 1'b0, 1'b1, "R8 done holds");
        idle_steps(3, 1'b1, 1'b1, "R8 done holds load high");
        // R9: restart from done, R10 load toggling inside
        run_block(1'b1, 1'b1, "blk2 R9");
        idle_steps(2, 1'b0, 1'b1, "R8 done again");
        // reset in the middle of a round
        step(1'b1, pk(4'b0000, 0, 1'b0, 1'b1), "R2 arm before reset");
        step(1'b0, pk(4'b0001, 0, 1'b0, 1'b0), "R3 pre-round");
        step(1'b0, pk(4'b1111, 1, 1'b0, 1'b0), "R4 round 1");
        @(negedge clk);
        rst_n = 1'b0;
        q.push_back('{v: pk(4'b0000, 0, 1'b0, 1'b0), tag: "R1 reset mid-run"});
        @(negedge clk);
        rst_n = 1'b1;
        q.push_back('{v: pk(4'b0000, 0, 1'b0, 1'b0), tag: "R1 out of reset"});
        idle_steps(2, 1'b0, 1'b0, "R2 idle after reset");
        run_block(1'b0, 1'b0, "blk3");
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule